// File: doc/BRIEF.md
# DMA Control-Byte Decoder with Transfer Counters

This block sits behind the register port of a simple two-port DMA engine. A CPU writes a byte-count limit, one start address per port, and a stream of control bytes to it. Each control byte is decoded into an action on a byte counter, two port address counters, a forced-ready flag, an interrupt-enable flag and an active-high interrupt output. The bus transfers themselves are not modelled. Each pulse on the transfer strobe stands for one moved byte and advances the counters while the engine is enabled.

Software runs a block in four steps: it programs the length and start addresses, issues a restart, enables the engine, and waits for the end-of-block interrupt. To chain blocks to consecutive memory, software uses the counter-restart command, which zeroes only the byte count and leaves both address counters where they stopped. A new length may be written before that restart. When the engine is idle, a restart is honoured only if another control byte was written just before it. CPUs without a hardware acknowledge cycle clear and mask the interrupt by writing the interrupt-mask command.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, active, irq and force_rdy are 0 and byte_cnt, addr_a and addr_b are 0.
- R2: Writes on wr_sel=1 set the block length, wr_sel=2 the port A start address and wr_sel=3 the port B start address. None of these changes any output by itself.
- R3: The control byte 0xCF (restart-all) is accepted while active or primed. It copies each non-fixed port's start address into its address counter, zeroes byte_cnt and clears force_rdy.
- R4: A restart byte (0xCF or 0xD3) written while inactive and not primed changes nothing. Any other byte written with wr_sel=0 primes the engine. A restart byte or a block end clears the primed state.
- R5: 0x87 sets active and 0x83 clears it.
- R6: A transfer strobe while active, with no write with wr_sel=0 in the same cycle, increments byte_cnt and each non-fixed address counter by one. A strobe while inactive changes nothing.
- R7: When an accepted strobe brings byte_cnt equal to the block length, active drops in the same update. irq rises if interrupts are enabled and stays 0 if they are not.
- R8: 0xD3 (restart-count), when accepted, zeroes byte_cnt and leaves addr_a and addr_b unchanged. The next block then ends at the length in force at that time.
- R9: 0xB3 sets force_rdy. A later accepted 0xCF clears it.
- R10: 0xAB enables interrupts. 0xAF drives irq to 0 and masks all later end-of-block interrupts until the next 0xAB.
- R11: A port whose fixed flag (fix_a or fix_b) is 1 is neither loaded nor incremented.
- R12: A byte that is not in the command list acts on nothing but the primed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control byte, 1 block length, 2 port A start, 3 port B start |
| wr_data | input | DATA_W | Write data; control bytes in bits 7:0 |
| xfer | input | 1 | One transferred byte |
| fix_a | input | 1 | Port A address is fixed |
| fix_b | input | 1 | Port B address is fixed |
| active | output | 1 | Engine enabled |
| byte_cnt | output | CNT_W | Bytes moved in current block |
| addr_a | output | ADDR_W | Port A address counter |
| addr_b | output | ADDR_W | Port B address counter |
| force_rdy | output | 1 | Forced-ready flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The decoder is tried with restart bytes preceded by nothing, by the disable byte, by an unknown byte and by the force-ready byte. These cases separate the priming rule from plain decoding. Blocks are run once with interrupts enabled and once after masking, which shows that the end of a block and the interrupt are separate events. The count-only restart is followed by transfers, which shows that the addresses carry on while the count starts again. A run with one port fixed shows that the two address counters are independent.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_LEN = 2'd1;
  localparam logic [1:0] SEL_STA = 2'd2;  // port A; port p uses SEL_STA + p

  localparam logic [7:0] CODE_LOAD  = 8'hCF;
  localparam logic [7:0] CODE_CONT  = 8'hD3;
  localparam logic [7:0] CODE_EN    = 8'h87;
  localparam logic [7:0] CODE_DIS   = 8'h83;
  localparam logic [7:0] CODE_FRC   = 8'hB3;
  localparam logic [7:0] CODE_IEN   = 8'hAB;
  localparam logic [7:0] CODE_IDIS  = 8'hAF;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_CONT,
    ACT_EN,
    ACT_DIS,
    ACT_FRC,
    ACT_IEN,
    ACT_IDIS
  } cmd_act_e;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_act_e   act,
  output logic       restart
);

  always_comb begin
    case (code)
      CODE_LOAD: act = ACT_LOAD;
      CODE_CONT: act = ACT_CONT;
      CODE_EN:   act = ACT_EN;
      CODE_DIS:  act = ACT_DIS;
      CODE_FRC:  act = ACT_FRC;
      CODE_IEN:  act = ACT_IEN;
      CODE_IDIS: act = ACT_IDIS;
      default:   act = ACT_NONE;
    endcase
  end

  assign restart = (act == ACT_LOAD) || (act == ACT_CONT);

endmodule

// File: rtl/dma_port_ctr.sv
module dma_port_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = !fixed && (load || step);
    addr_d  = load ? start : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  input  logic              fix_a,
  input  logic              fix_b,
  output logic              active,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic              force_rdy,
  output logic              irq
);

  localparam int NPORT = 2;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // control byte decode
  cmd_act_e act;
  logic     is_restart;
  dma_cmd_decode u_dec (
    .code    (wr_data[7:0]),
    .act     (act),
    .restart (is_restart)
  );

  logic cmd_wr, len_wr;
  assign cmd_wr = wr_en && (wr_sel == SEL_CMD);
  assign len_wr = wr_en && (wr_sel == SEL_LEN);

  // state registers
  logic             active_q, active_d;
  logic             primed_q, primed_d;
  logic             frc_q, frc_d;
  logic             ie_q, ie_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] len_q;
  logic             cnt_en;

  logic accept, do_load, do_cont, step, blk_end;

  always_comb begin
    accept  = active_q || primed_q;
    do_load = cmd_wr && (act == ACT_LOAD) && accept;
    do_cont = cmd_wr && (act == ACT_CONT) && accept;
    step    = active_q && xfer && !cmd_wr;
    cnt_inc = cnt_q + 1'b1;
    blk_end = step && (cnt_inc == len_q);
  end

  // next-state logic
  always_comb begin
    active_d = active_q;
    primed_d = primed_q;
    frc_d    = frc_q;
    ie_d     = ie_q;
    irq_d    = irq_q;
    if (cmd_wr) begin
      primed_d = !is_restart;
      case (act)
        ACT_EN:   active_d = 1'b1;
        ACT_DIS:  active_d = 1'b0;
        ACT_FRC:  frc_d    = 1'b1;
        ACT_LOAD: if (do_load) frc_d = 1'b0;
        ACT_IEN:  ie_d     = 1'b1;
        ACT_IDIS: begin
          ie_d  = 1'b0;
          irq_d = 1'b0;
        end
        default: ;
      endcase
    end else if (blk_end) begin
      active_d = 1'b0;
      primed_d = 1'b0;
      if (ie_q) irq_d = 1'b1;
    end
  end

  always_comb begin
    cnt_en = do_load || do_cont || step;
    cnt_d  = (do_load || do_cont) ? '0 : cnt_inc;
  end

  // register processes
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      active_q <= 1'b0;
      primed_q <= 1'b0;
      frc_q    <= 1'b0;
      ie_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      primed_q <= primed_d;
      frc_q    <= frc_d;
      ie_q     <= ie_d;
      irq_q    <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    len_q <= '0;
    else if (len_wr) len_q <= wr_data[CNT_W-1:0];
  end

  // per-port start registers and address counters
  logic [NPORT-1:0]  fix_vec;
  logic [ADDR_W-1:0] addr_arr [NPORT];
  assign fix_vec = {fix_b, fix_a};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [ADDR_W-1:0] start_q;
    logic              start_wr;
    assign start_wr = wr_en && (wr_sel == SEL_STA + 2'(p));

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)      start_q <= '0;
      else if (start_wr) start_q <= wr_data[ADDR_W-1:0];
    end

    dma_port_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_i_n),
      .fixed (fix_vec[p]),
      .load  (do_load),
      .step  (step),
      .start (start_q),
      .addr  (addr_arr[p])
    );
  end

  assign active    = active_q;
  assign byte_cnt  = cnt_q;
  assign addr_a    = addr_arr[0];
  assign addr_b    = addr_arr[1];
  assign force_rdy = frc_q;
  assign irq       = irq_q;

endmodule

// File: rtl/dma_cmd_ctrl_chk.sv
module dma_cmd_ctrl_chk
  import dma_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [7:0]        wr_cmd,
  input logic              xfer,
  input logic              fix_a,
  input logic              fix_b,
  input logic              active,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic              force_rdy,
  input logic              irq
);

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_sel == SEL_CMD);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!active && !irq && !force_rdy));

  a_r5_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_cmd == CODE_EN) |=> active);

  a_r6_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cmd_wr) |=> $stable(byte_cnt));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xfer && !cmd_wr) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

  a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(active) && !active));

  a_r9_force_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_rdy) |-> $past(cmd_wr && wr_cmd == CODE_FRC));

  a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_cmd == CODE_IDIS) |=> !irq);

  a_r11_fixed_a: assert property (@(posedge clk) disable iff (!rst_n)
    fix_a |=> $stable(addr_a));

  a_r11_fixed_b: assert property (@(posedge clk) disable iff (!rst_n)
    fix_b |=> $stable(addr_b));

endmodule

bind dma_cmd_ctrl dma_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_cmd    (wr_data[7:0]),
  .xfer      (xfer),
  .fix_a     (fix_a),
  .fix_b     (fix_b),
  .active    (active),
  .byte_cnt  (byte_cnt),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .force_rdy (force_rdy),
  .irq       (irq)
);

// File: tb/dma_cmd_ctrl_bench.sv
module dma_cmd_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic        xfer = 1'b0;
  logic        fix_a = 1'b0;
  logic        fix_b = 1'b0;
  logic        active, force_rdy, irq;
  logic [15:0] byte_cnt, addr_a, addr_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cmd_ctrl u_dma_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer(xfer), .fix_a(fix_a), .fix_b(fix_b), .active(active), .byte_cnt(byte_cnt),
    .addr_a(addr_a), .addr_b(addr_b), .force_rdy(force_rdy), .irq(irq)
  );

  // row: xfer, sel, data | expected active, cnt, addr_a, addr_b, irq, force_rdy
  localparam logic [69:0] TAB [0:N-1] = '{
    {1'b0,2'd1,16'h0003, 1'b0,16'd0,16'h0000,16'h0000,1'b0,1'b0}, // 0 R2 len
    {1'b0,2'd2,16'h1000, 1'b0,16'd0,16'h0000,16'h0000,1'b0,1'b0}, // 1 R2 start A
    {1'b0,2'd3,16'h2000, 1'b0,16'd0,16'h0000,16'h0000,1'b0,1'b0}, // 2 R2 start B
    {1'b0,2'd0,16'h00CF, 1'b0,16'd0,16'h0000,16'h0000,1'b0,1'b0}, // 3 R4 unprimed load
    {1'b0,2'd0,16'h0083, 1'b0,16'd0,16'h0000,16'h0000,1'b0,1'b0}, // 4 R5 disable primes
    {1'b0,2'd0,16'h00CF, 1'b0,16'd0,16'h1000,16'h2000,1'b0,1'b0}, // 5 R3 load
    {1'b0,2'd0,16'h00AB, 1'b0,16'd0,16'h1000,16'h2000,1'b0,1'b0}, // 6 R10 int enable
    {1'b0,2'd0,16'h0087, 1'b1,16'd0,16'h1000,16'h2000,1'b0,1'b0}, // 7 R5 enable
    {1'b1,2'd0,16'h0000, 1'b1,16'd1,16'h1001,16'h2001,1'b0,1'b0}, // 8 R6
    {1'b1,2'd0,16'h0000, 1'b1,16'd2,16'h1002,16'h2002,1'b0,1'b0}, // 9 R6
    {1'b1,2'd0,16'h0000, 1'b0,16'd3,16'h1003,16'h2003,1'b1,1'b0}, // 10 R7 end+irq
    {1'b1,2'd0,16'h0000, 1'b0,16'd3,16'h1003,16'h2003,1'b1,1'b0}, // 11 R6 idle strobe
    {1'b0,2'd1,16'h0002, 1'b0,16'd3,16'h1003,16'h2003,1'b1,1'b0}, // 12 R8 new len
    {1'b0,2'd0,16'h00D3, 1'b0,16'd3,16'h1003,16'h2003,1'b1,1'b0}, // 13 R4 unprimed cont
    {1'b0,2'd0,16'h0000, 1'b0,16'd3,16'h1003,16'h2003,1'b1,1'b0}, // 14 R12 unknown
    {1'b0,2'd0,16'h00D3, 1'b0,16'd0,16'h1003,16'h2003,1'b1,1'b0}, // 15 R8 cont
    {1'b0,2'd0,16'h00AF, 1'b0,16'd0,16'h1003,16'h2003,1'b0,1'b0}, // 16 R10 mask
    {1'b0,2'd0,16'h0087, 1'b1,16'd0,16'h1003,16'h2003,1'b0,1'b0}, // 17 R5
    {1'b1,2'd0,16'h0000, 1'b1,16'd1,16'h1004,16'h2004,1'b0,1'b0}, // 18 R8 resume
    {1'b1,2'd0,16'h0000, 1'b0,16'd2,16'h1005,16'h2005,1'b0,1'b0}, // 19 R7 no irq masked
    {1'b0,2'd0,16'h00B3, 1'b0,16'd2,16'h1005,16'h2005,1'b0,1'b1}, // 20 R9 force
    {1'b0,2'd0,16'h00CF, 1'b0,16'd0,16'h1000,16'h2000,1'b0,1'b0}, // 21 R9 load clears
    {1'b0,2'd0,16'h00B3, 1'b0,16'd0,16'h1000,16'h2000,1'b0,1'b1}  // 22 R9 force after
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2:    return "R2";
      3, 13:      return "R4";
      4, 7, 17:   return "R5";
      5:          return "R3";
      6, 16:      return "R10";
      8, 9, 11:   return "R6";
      10, 19:     return "R7";
      12, 15, 18: return "R8";
      14:         return "R12";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic x, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    xfer    = x;
    wr_en   = !x;
    wr_sel  = sel;
    wr_data = d;
    @(negedge clk);
    xfer  = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_zero(input string tag);
    check(tag, "active",    {15'd0, active},    16'h0);
    check(tag, "irq",       {15'd0, irq},       16'h0);
    check(tag, "force_rdy", {15'd0, force_rdy}, 16'h0);
    check(tag, "byte_cnt",  byte_cnt,           16'h0);
    check(tag, "addr_a",    addr_a,             16'h0);
    check(tag, "addr_b",    addr_b,             16'h0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    check_zero("R1");   // R1 while held in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_zero("R1");   // R1 after release

    for (int i = 0; i < N; i++) begin
      logic [69:0] v;
      v = TAB[i];
      step(v[69], v[68:67], v[66:51]);
      check(req_of(i), "active",    {15'd0, active},    {15'd0, v[50]});
      check(req_of(i), "byte_cnt",  byte_cnt,           v[49:34]);
      check(req_of(i), "addr_a",    addr_a,             v[33:18]);
      check(req_of(i), "addr_b",    addr_b,             v[17:2]);
      check(req_of(i), "irq",       {15'd0, irq},       {15'd0, v[1]});
      check(req_of(i), "force_rdy", {15'd0, force_rdy}, {15'd0, v[0]});
    end

    // R1: reset from a busy state clears everything
    apply_reset();
    check_zero("R1");

    // R11: fixed port A is never loaded or stepped
    fix_a = 1'b1;
    step(1'b0, 2'd2, 16'h3000);
    step(1'b0, 2'd3, 16'h4000);
    step(1'b0, 2'd0, 16'h0083);
    step(1'b0, 2'd0, 16'h00CF);
    check("R11", "addr_a after load", addr_a, 16'h0000);
    check("R11", "addr_b after load", addr_b, 16'h4000);
    step(1'b0, 2'd0, 16'h0087);
    step(1'b1, 2'd0, 16'h0000);
    check("R11", "addr_a after strobe", addr_a, 16'h0000);
    check("R11", "addr_b after strobe", addr_b, 16'h4001);
    check("R6",  "byte_cnt with fixed port", byte_cnt, 16'h0001);

    // R12: unknown byte while active has no effect on outputs
    step(1'b0, 2'd0, 16'h0055);
    check("R12", "active", {15'd0, active}, 16'h0001);
    check("R12", "byte_cnt", byte_cnt, 16'h0001);
    fix_a = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule